// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a three-wire serial EEPROM holding 64 words of 16 bits. A master raises chip select while the serial clock is low, then clocks in bits on `din` at rising clock edges. Any zeros before the first 1 are skipped. That 1 is the start bit. It is followed by a two-bit opcode and a six-bit word address, both sent MSB first. The `prot_sel` pin chooses between two opcode groups: one for the memory array and one for the protection register. When the opcode is 00, the top two address bits extend it. Three commands then take a 16-bit data word.

The block decodes each instruction and issues a one-clock command strobe to a downstream protection controller. It also presents the command code, the address and the write data. It owns the word array and a write-enable latch. For a read it loads an output shift register and drives a dummy 0 followed by the data, MSB first. Dropping chip select ends any instruction at once.

All logic runs on the serial clock itself, so the interface is fully static. The command outputs act as a valid-only stream. `cmd_valid` is the valid flag, and no ready exists because the master sets the pace. A consumer that cannot take a command in the cycle `cmd_valid` is high loses it. Array writes can instead be vetoed through `wr_inhibit`, which the controller drives combinationally from `cmd_code` and `cmd_addr`.

Top module: `mw_eeprom_front`

## Requirements
- R1: While chip select is high, zeros before the first 1 on `din` are ignored. The first 1 is the start bit, and the next 8 bits are opcode[1:0] then address[5:0], all MSB first.
- R2: With `prot_sel`=0, the opcodes decode as follows:
  - 10 is READ (code 1).
  - 01 is WRITE (code 2).
  - 11 is PAWRITE (code 3).
  - 00 with address[5:4]=01 is WRALL (code 4).
  - 00 with address[5:4]=11 is WEN (code 5).
  - 00 with address[5:4]=00 is WDS (code 6).
- R3: With `prot_sel`=1, the opcodes decode as follows:
  - 10 is PRREAD (code 7).
  - 01 is PRWRITE (code 8).
  - 11 with address 111111 is PRCLEAR (code 9).
  - 00 with address[5:4]=11 is PREN (code 10).
  - 00 with address 000000 is PRDS (code 11).
- R4: Any other combination is unrecognised. It gives no strobe and no effect, and `cmd_code` reads 0.
- R5: `cmd_valid` is high for exactly one clock.
  - For commands without data, it rises after the edge that samples address bit 0.
  - For WRITE, PAWRITE and WRALL, it rises after the edge that samples the 16th data bit, and `cmd_wdata` then holds that word.
- R6: All commands except READ, WDS and PRREAD require `wr_allow`=1 at their final edge. Otherwise they give no strobe and change nothing.
- R7: On READ, `dout_en` rises after the edge that samples address bit 0, with `dout`=0 (the dummy bit). Each following edge presents the next data bit, D15 first.
- R8: On PRREAD, the dummy 0 is followed by `prot_word[8:0]`, MSB first.
- R9: The write-enable latch is cleared by power-on reset and by WDS, and set by WEN. While it is clear, the array does not change.
- R10: WRITE and PAWRITE store the word at the address, and WRALL stores it in every word. None of them writes if `wr_inhibit` is 1 at the final edge.
- R11: Chip select low at any point aborts the instruction. It forces `dout_en`, `dout` and `cmd_valid` to 0, and a partial data word writes nothing.
- R12: After power-on reset with chip select low, `dout_en`, `dout`, `cmd_valid` and `cmd_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| din | input | 1 | Serial data in |
| prot_sel | input | 1 | Selects the protection-register opcode group |
| wr_allow | input | 1 | Write permission pin |
| wr_inhibit | input | 1 | Controller veto of the pending array write |
| prot_word | input | 9 | Protection register content plus flag, for PRREAD |
| dout | output | 1 | Serial data out, 0 when not enabled |
| dout_en | output | 1 | Output enable (models the tri-state driver) |
| cmd_valid | output | 1 | One-clock command strobe |
| cmd_code | output | 4 | Decoded command code, 0 if unrecognised |
| cmd_addr | output | 6 | Address field of the current command |
| cmd_wdata | output | 16 | Data word of the current command |

## Verification
The bench targets the extended-opcode corners: an address that is one bit away from PRCLEAR or PRDS, and the reserved 00/10 slot. A decoder that ignores the low address bits would strobe on these. It checks that the first data bit follows a dummy 0, so an output register loaded one edge late or early shows up as a one-bit shift. It also drops chip select part-way through a data word and part-way through a read, which catches a counter or output enable that survives the abort. Finally, it checks that WDS, power-on reset, `wr_allow` low and `wr_inhibit` each leave a stored word untouched.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_READ    = 4'd1,
    CMD_WRITE   = 4'd2,
    CMD_PAWRITE = 4'd3,
    CMD_WRALL   = 4'd4,
    CMD_WEN     = 4'd5,
    CMD_WDS     = 4'd6,
    CMD_PRREAD  = 4'd7,
    CMD_PRWRITE = 4'd8,
    CMD_PRCLEAR = 4'd9,
    CMD_PREN    = 4'd10,
    CMD_PRDS    = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HDR,
    RX_DATA,
    RX_DONE
  } rx_st_e;
endpackage

// File: rtl/mw_rx.sv
module mw_rx
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              need_data,
  output logic              hdr_last,
  output logic [ADDR_W+1:0] hdr_word,
  output logic              data_last,
  output logic [DATA_W-1:0] data_word
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W + 1);

  rx_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-2:0] hsh_q;
  logic [DATA_W-2:0] dsh_q;

  assign hdr_last  = (st_q == RX_HDR)  && (cnt_q == CNT_W'(HDR_W - 1));
  assign data_last = (st_q == RX_DATA) && (cnt_q == CNT_W'(DATA_W - 1));
  assign hdr_word  = {hsh_q, din};
  assign data_word = {dsh_q, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      hsh_q <= '0;
      dsh_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (din) begin
            st_q  <= RX_HDR;
            cnt_q <= '0;
          end
        end
        RX_HDR: begin
          hsh_q <= hdr_word[HDR_W-2:0];
          if (hdr_last) begin
            cnt_q <= '0;
            st_q  <= need_data ? RX_DATA : RX_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          dsh_q <= data_word[DATA_W-2:0];
          if (data_last) begin
            st_q <= RX_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_DONE;
      endcase
    end
  end
endmodule

// File: rtl/mw_decode.sv
module mw_decode
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              pre,
  input  logic [ADDR_W+1:0] hdr,
  output cmd_e              code,
  output logic              need_data,
  output logic              need_w
);
  logic [1:0]        op;
  logic [ADDR_W-1:0] a;
  logic [1:0]        ext;

  assign op  = hdr[ADDR_W+1:ADDR_W];
  assign a   = hdr[ADDR_W-1:0];
  assign ext = a[ADDR_W-1:ADDR_W-2];

  always_comb begin
    code = CMD_NONE;
    if (!pre) begin
      case (op)
        2'b10: code = CMD_READ;
        2'b01: code = CMD_WRITE;
        2'b11: code = CMD_PAWRITE;
        default: begin
          case (ext)
            2'b01:   code = CMD_WRALL;
            2'b11:   code = CMD_WEN;
            2'b00:   code = CMD_WDS;
            default: code = CMD_NONE;
          endcase
        end
      endcase
    end else begin
      case (op)
        2'b10: code = CMD_PRREAD;
        2'b01: code = CMD_PRWRITE;
        2'b11: code = (&a) ? CMD_PRCLEAR : CMD_NONE;
        default: begin
          if (ext == 2'b11)  code = CMD_PREN;
          else if (~|a)      code = CMD_PRDS;
          else               code = CMD_NONE;
        end
      endcase
    end
  end

  always_comb begin
    need_data = (code == CMD_WRITE) || (code == CMD_PAWRITE) || (code == CMD_WRALL);
    need_w    = !((code == CMD_READ) || (code == CMD_WDS) ||
                  (code == CMD_PRREAD) || (code == CMD_NONE));
  end
endmodule

// File: rtl/mw_txsr.sv
module mw_txsr #(
  parameter int DATA_W = 16,
  parameter int PROT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mem,
  input  logic              load_prot,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [PROT_W-1:0] prot_word,
  output logic              dout,
  output logic              dout_en
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr_q;
  logic            en_q;
  logic [SR_W-1:0] prot_img;

  assign prot_img = SR_W'(prot_word) << (DATA_W - PROT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      en_q <= 1'b0;
    end else if (load_mem) begin
      sr_q <= {1'b0, mem_word};
      en_q <= 1'b1;
    end else if (load_prot) begin
      sr_q <= prot_img;
      en_q <= 1'b1;
    end else if (en_q) begin
      sr_q <= {sr_q[SR_W-2:0], 1'b0};
    end
  end

  assign dout_en = en_q;
  assign dout    = en_q & sr_q[SR_W-1];
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              set_wen,
  input  logic              clr_wen,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              wen_q;
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       wen_q <= 1'b0;
    else if (clr_wen) wen_q <= 1'b0;
    else if (set_wen) wen_q <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wen_q && (wr_all || (wr_one && (waddr == ADDR_W'(g)))))
        word_q <= wdata;
    end
    assign words[g] = word_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PROT_W = 9
) (
  input  logic              por_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              din,
  input  logic              prot_sel,
  input  logic              wr_allow,
  input  logic              wr_inhibit,
  input  logic [PROT_W-1:0] prot_word,
  output logic              dout,
  output logic              dout_en,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata
);
  logic              sess_rst_n;
  logic              hdr_last, data_last;
  logic [ADDR_W+1:0] hdr_word;
  logic [DATA_W-1:0] data_word;
  cmd_e              dec_code;
  logic              dec_need_data, dec_need_w;
  cmd_e              code_q;
  logic              need_w_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              valid_q;
  logic              fire_hdr, fire_data;
  logic [DATA_W-1:0] mem_rd;

  assign sess_rst_n = por_n & cs;

  mw_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk       (sclk),
    .rst_n     (sess_rst_n),
    .din       (din),
    .need_data (dec_need_data),
    .hdr_last  (hdr_last),
    .hdr_word  (hdr_word),
    .data_last (data_last),
    .data_word (data_word)
  );

  mw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .pre       (prot_sel),
    .hdr       (hdr_word),
    .code      (dec_code),
    .need_data (dec_need_data),
    .need_w    (dec_need_w)
  );

  assign fire_hdr  = hdr_last && (dec_code != CMD_NONE) && !dec_need_data &&
                     (!dec_need_w || wr_allow);
  assign fire_data = data_last && (code_q != CMD_NONE) && (!need_w_q || wr_allow);

  always_ff @(posedge sclk or negedge sess_rst_n) begin
    if (!sess_rst_n) begin
      code_q   <= CMD_NONE;
      need_w_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= fire_hdr || fire_data;
      if (hdr_last) begin
        code_q   <= dec_code;
        need_w_q <= dec_need_w;
        addr_q   <= hdr_word[ADDR_W-1:0];
      end
      if (data_last) wdata_q <= data_word;
    end
  end

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (sclk),
    .por_n   (por_n),
    .set_wen (fire_hdr && (dec_code == CMD_WEN)),
    .clr_wen (fire_hdr && (dec_code == CMD_WDS)),
    .wr_one  (fire_data && !wr_inhibit &&
              ((code_q == CMD_WRITE) || (code_q == CMD_PAWRITE))),
    .wr_all  (fire_data && !wr_inhibit && (code_q == CMD_WRALL)),
    .waddr   (addr_q),
    .wdata   (data_word),
    .raddr   (hdr_word[ADDR_W-1:0]),
    .rdata   (mem_rd)
  );

  mw_txsr #(.DATA_W(DATA_W), .PROT_W(PROT_W)) u_tx (
    .clk       (sclk),
    .rst_n     (sess_rst_n),
    .load_mem  (fire_hdr && (dec_code == CMD_READ)),
    .load_prot (fire_hdr && (dec_code == CMD_PRREAD)),
    .mem_word  (mem_rd),
    .prot_word (prot_word),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  assign cmd_valid = valid_q;
  assign cmd_code  = code_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wdata_q;
endmodule

// File: rtl/mw_front_chk.sv
module mw_front_chk (
  input logic       por_n,
  input logic       cs,
  input logic       sclk,
  input logic       wr_allow,
  input logic       dout,
  input logic       dout_en,
  input logic       cmd_valid,
  input logic [3:0] cmd_code
);
  // R5
  strobe_single_chk: assert property (@(posedge sclk) disable iff (!(por_n && cs))
    cmd_valid |=> !cmd_valid);

  // R4
  strobe_code_chk: assert property (@(posedge sclk) disable iff (!(por_n && cs))
    cmd_valid |-> (cmd_code != 4'd0));

  // R6
  write_perm_chk: assert property (@(posedge sclk) disable iff (!(por_n && cs))
    (cmd_valid && (cmd_code != 4'd1) && (cmd_code != 4'd6) && (cmd_code != 4'd7))
      |-> $past(wr_allow));

  // R7
  dummy_bit_chk: assert property (@(posedge sclk) disable iff (!(por_n && cs))
    $rose(dout_en) |-> !dout);

  // R11
  abort_quiet_chk: assert property (@(posedge sclk) disable iff (!por_n)
    !cs |-> (!dout_en && !cmd_valid));

  // R12
  idle_low_chk: assert property (@(posedge sclk) disable iff (!por_n)
    !dout_en |-> !dout);
endmodule

bind mw_eeprom_front mw_front_chk u_chk (
  .por_n     (por_n),
  .cs        (cs),
  .sclk      (sclk),
  .wr_allow  (wr_allow),
  .dout      (dout),
  .dout_en   (dout_en),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code)
);

// File: tb/sim_mw_eeprom_front.sv
module sim_mw_eeprom_front;
  logic        por_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic        prot_sel = 1'b0, wr_allow = 1'b0, wr_inhibit = 1'b0;
  logic [8:0]  prot_word = 9'h000;
  logic        dout, dout_en, cmd_valid;
  logic [3:0]  cmd_code;
  logic [5:0]  cmd_addr;
  logic [15:0] cmd_wdata;

  int n_chk = 0, n_fail = 0, n_str = 0;
  logic [3:0]  last_code = 4'd0;
  logic        rd_dummy, rd_en;
  logic [15:0] rd_word;
  logic        done = 1'b0;

  mw_eeprom_front u0 (
    .por_n(por_n), .cs(cs), .sclk(sclk), .din(din), .prot_sel(prot_sel),
    .wr_allow(wr_allow), .wr_inhibit(wr_inhibit), .prot_word(prot_word),
    .dout(dout), .dout_en(dout_en), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
  );

  // vector: {pre, w, op[1:0], addr[5:0], data[15:0], exp_valid, exp_code[3:0]}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b00, 6'b110000, 16'h0000, 1'b1, 4'd5},   // R2 WEN
    {1'b0, 1'b1, 2'b01, 6'b000011, 16'hA5C3, 1'b1, 4'd2},   // R2 WRITE
    {1'b0, 1'b1, 2'b11, 6'b000100, 16'h1234, 1'b1, 4'd3},   // R2 PAWRITE
    {1'b0, 1'b0, 2'b01, 6'b000011, 16'hFFFF, 1'b0, 4'd0},   // R6 W low
    {1'b0, 1'b1, 2'b00, 6'b100000, 16'h0000, 1'b0, 4'd0},   // R4 reserved
    {1'b0, 1'b0, 2'b00, 6'b000000, 16'h0000, 1'b1, 4'd6},   // R2 WDS
    {1'b0, 1'b0, 2'b10, 6'b000011, 16'h0000, 1'b1, 4'd1},   // R2 READ
    {1'b1, 1'b1, 2'b11, 6'b111111, 16'h0000, 1'b1, 4'd9},   // R3 PRCLEAR
    {1'b1, 1'b1, 2'b11, 6'b111110, 16'h0000, 1'b0, 4'd0},   // R4 near PRCLEAR
    {1'b1, 1'b1, 2'b00, 6'b110101, 16'h0000, 1'b1, 4'd10},  // R3 PREN
    {1'b1, 1'b1, 2'b00, 6'b000000, 16'h0000, 1'b1, 4'd11},  // R3 PRDS
    {1'b1, 1'b1, 2'b00, 6'b000001, 16'h0000, 1'b0, 4'd0},   // R4 near PRDS
    {1'b1, 1'b1, 2'b01, 6'b001010, 16'h0000, 1'b1, 4'd8},   // R3 PRWRITE
    {1'b1, 1'b0, 2'b10, 6'b000000, 16'h0000, 1'b1, 4'd7},   // R3 PRREAD
    {1'b1, 1'b0, 2'b00, 6'b110000, 16'h0000, 1'b0, 4'd0},   // R6 PREN W low
    {1'b0, 1'b1, 2'b00, 6'b010000, 16'h0000, 1'b1, 4'd4}    // R2 WRALL
  };

  always @(posedge sclk) begin
    #2;
    if (cmd_valid) begin
      n_str++;
      last_code = cmd_code;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    din = b; #5 sclk = 1'b1; #10 sclk = 1'b0; #5;
  endtask

  task automatic begin_cs(input logic pre, input logic w);
    prot_sel = pre; wr_allow = w; n_str = 0; cs = 1'b1; #5;
  endtask

  task automatic end_cs();
    cs = 1'b0; din = 1'b0; #10;
  endtask

  task automatic send_hdr(input int zeros, input logic [1:0] op, input logic [5:0] a);
    for (int i = 0; i < zeros; i++) clk_bit(1'b0);
    clk_bit(1'b1);
    for (int i = 1; i >= 0; i--) clk_bit(op[i]);
    for (int i = 5; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) clk_bit(d[i]);
  endtask

  task automatic instr(input logic pre, input logic w, input logic [1:0] op,
                       input logic [5:0] a, input logic [15:0] d);
    begin_cs(pre, w);
    send_hdr(0, op, a);
    if (!pre && (op == 2'b01 || op == 2'b11 || (op == 2'b00 && a[5:4] == 2'b01)))
      send_data(d, 16);
    end_cs();
  endtask

  task automatic do_read(input logic pre, input int zeros, input logic [5:0] a);
    begin_cs(pre, 1'b0);
    send_hdr(zeros, 2'b10, a);
    rd_dummy = dout; rd_en = dout_en;
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0);
      rd_word[i] = dout;
    end
    end_cs();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #25 por_n = 1'b1; #10;
    // R12 reset state
    check("R12 dout_en", dout_en, 0);
    check("R12 dout", dout, 0);
    check("R12 cmd_valid", cmd_valid, 0);
    check("R12 cmd_code", cmd_code, 0);

    for (int v = 0; v < NV; v++) begin
      logic [30:0] e;
      e = VEC[v];
      instr(e[30], e[29], e[28:27], e[26:21], e[20:5]);
      check($sformatf("R2/R3/R4 v%0d strobes", v), n_str, int'(e[4]));
      if (e[4]) check($sformatf("R2/R3 v%0d code", v), last_code, int'(e[3:0]));
    end

    // R10 WRALL, R7 read dummy and data
    instr(1'b0, 1'b1, 2'b00, 6'b110000, 16'h0);
    instr(1'b0, 1'b1, 2'b00, 6'b010000, 16'hBEEF);
    do_read(1'b0, 0, 6'd5);
    check("R10 wrall word5", rd_word, 16'hBEEF);
    check("R7 dummy", rd_dummy, 0);
    check("R7 dout_en", rd_en, 1);
    do_read(1'b0, 0, 6'd62);
    check("R10 wrall word62", rd_word, 16'hBEEF);

    // R9 power-on clears write enable
    por_n = 1'b0; #10 por_n = 1'b1; #10;
    instr(1'b0, 1'b1, 2'b01, 6'd5, 16'h1111);
    do_read(1'b0, 0, 6'd5);
    check("R9 por blocks write", rd_word, 16'hBEEF);

    // R5 strobe timing, R10 write
    begin_cs(1'b0, 1'b1);
    send_hdr(0, 2'b00, 6'b111111);
    check("R5 strobe after last hdr bit", cmd_valid, 1);
    clk_bit(1'b0);
    check("R5 strobe one clock", cmd_valid, 0);
    end_cs();
    begin_cs(1'b0, 1'b1);
    send_hdr(0, 2'b01, 6'd3);
    send_data(16'hA5C3, 15);
    check("R5 no strobe before last data bit", cmd_valid, 0);
    send_data(16'h0001 << 0, 0);
    clk_bit(1'b1);
    check("R5 strobe after data", cmd_valid, 1);
    check("R5 wdata", cmd_wdata, 16'hA5C3);
    check("R5 addr", cmd_addr, 3);
    end_cs();
    do_read(1'b0, 0, 6'd3);
    check("R10 write word3", rd_word, 16'hA5C3);
    instr(1'b0, 1'b1, 2'b11, 6'd7, 16'h0F0F);
    do_read(1'b0, 0, 6'd7);
    check("R10 pawrite word7", rd_word, 16'h0F0F);

    // R6 W low blocks write
    instr(1'b0, 1'b0, 2'b01, 6'd3, 16'h0000);
    do_read(1'b0, 0, 6'd3);
    check("R6 w low write", rd_word, 16'hA5C3);

    // R10 inhibit
    wr_inhibit = 1'b1;
    instr(1'b0, 1'b1, 2'b01, 6'd3, 16'h0000);
    wr_inhibit = 1'b0;
    do_read(1'b0, 0, 6'd3);
    check("R10 inhibit write", rd_word, 16'hA5C3);

    // R11 abort mid data and mid read
    begin_cs(1'b0, 1'b1);
    send_hdr(0, 2'b01, 6'd3);
    send_data(16'h0000, 8);
    end_cs();
    check("R11 abort no strobe", n_str, 0);
    do_read(1'b0, 0, 6'd3);
    check("R11 abort no write", rd_word, 16'hA5C3);
    begin_cs(1'b0, 1'b0);
    send_hdr(0, 2'b10, 6'd3);
    clk_bit(1'b0); clk_bit(1'b0);
    cs = 1'b0; #1;
    check("R11 dout_en off", dout_en, 0);
    check("R11 dout off", dout, 0);
    #9;

    // R9 WDS blocks writes
    instr(1'b0, 1'b0, 2'b00, 6'b000000, 16'h0);
    instr(1'b0, 1'b1, 2'b01, 6'd3, 16'h0000);
    do_read(1'b0, 0, 6'd3);
    check("R9 wds blocks write", rd_word, 16'hA5C3);

    // R8 protect read
    prot_word = 9'h1A5;
    do_read(1'b1, 0, 6'd0);
    check("R8 dummy", rd_dummy, 0);
    check("R8 prot bits", rd_word[15:7], 9'h1A5);

    // R1 leading zeros ignored
    do_read(1'b0, 3, 6'd3);
    check("R1 leading zeros", rd_word, 16'hA5C3);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule